// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block sequences the output-offset null cycle of a multi-channel signal path. A serial configuration port reports each completed register write and also provides an active-low select line. When that select line rises after at least one write, the block starts a calibration run. A manual trigger pulse starts a run as well. Each run first waits a fixed settling interval. The block then shorts the signal inputs together and finds an offset-correction DAC code by successive approximation. That search uses one comparator bit, which the analog stage feeds back.

Durations are given in nanoseconds and converted to clock cycles from the clock frequency parameter. The search window is divided into one equal slot per code bit, and bits are decided from the most significant down. Triggers that arrive while a run is in progress are dropped. Taking the chip-enable input low puts the block in standby. Standby aborts any run and discards the correction, so the code reads as not valid until a fresh run completes. A change on the gain-select input raises an advisory flag that a run is worth doing, but it never starts one on its own.

Top module: `offset_cal_seq`

States and transitions of the sequencer:
- `ST_IDLE` → `ST_SETTLE` on an accepted start request.
- `ST_SETTLE` → `ST_SEARCH` when the settle timer expires.
- `ST_SEARCH` stays in `ST_SEARCH` on each slot expiry that is not the last.
- `ST_SEARCH` → `ST_IDLE` when the last slot expires.
- Any state → `ST_IDLE` whenever `chip_on` is low.

## Requirements
- R1: After reset the outputs are as follows: `cal_busy`=0, `short_inputs`=0, `code_valid`=0 and `cal_advised`=0. `dac_code` holds midscale, which is 1<<(CODE_W-1) (32 for the 6-bit default).
- R2: If `word_written` pulsed since the previous rising edge of `link_sel_n`, the next rising edge of `link_sel_n` starts a run. `cal_busy` is 1 in the first cycle after the clock edge that samples `link_sel_n` high. `word_written` pulsing in the same cycle as the rising edge also counts.
- R3: A rising edge of `link_sel_n` with no write since the previous rising edge starts no run, and `cal_busy` stays 0.
- R4: A one-cycle `manual_go` pulse while idle starts a run, and `cal_busy` is 1 in the cycle after the pulse is sampled.
- R5: A run keeps `cal_busy` high for SETTLE_CYC + CODE_W*SLOT_CYC cycles. SETTLE_CYC is CLK_MHZ*SETTLE_NS/1000, and SLOT_CYC is (CLK_MHZ*SEARCH_NS/1000)/CODE_W; the defaults give 50 and 41, so 296 cycles in all. `short_inputs` is 0 for the first SETTLE_CYC busy cycles and 1 for the remaining CODE_W*SLOT_CYC cycles. It falls together with `cal_busy`.
- R6: In each slot one bit is trialled as 1, starting from the MSB. At the end of the slot the bit is cleared if `cmp_high`=1, meaning the offset is too high, and kept otherwise. The finished code is the largest code for which `cmp_high` reads 0. `code_valid` becomes 1 in the cycle `cal_busy` falls.
- R7: `manual_go` pulses and write-then-select sequences that arrive while `cal_busy`=1 are discarded. No second run follows.
- R8: While `chip_on` is 0 the following hold:
  - The cycle after `chip_on` is sampled low, `cal_busy`, `short_inputs` and `code_valid` are 0 and `dac_code` returns to midscale.
  - Triggers start nothing.
  - After `chip_on` returns to 1, `code_valid` stays 0 until a run completes.
- R9: A change on `gain_hi` sets `cal_advised` to 1 in the following cycle and does not start a run. The next run to complete clears `cal_advised`.
- R10: While idle with `chip_on`=1, `dac_code` holds its value whatever `cmp_high` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_on | input | 1 | Chip enable; low selects standby |
| gain_hi | input | 1 | Gain-select level; any change advises a run |
| link_sel_n | input | 1 | Active-low serial select; its rising edge may start a run |
| word_written | input | 1 | One-cycle pulse per completed register write |
| manual_go | input | 1 | One-cycle pulse requesting a run |
| cmp_high | input | 1 | Comparator: 1 when the output offset is above zero at the present code |
| cal_busy | output | 1 | A run is in progress |
| short_inputs | output | 1 | Signal inputs shorted for the search |
| dac_code | output | CODE_W | Offset-correction DAC code |
| code_valid | output | 1 | `dac_code` holds the result of a completed run |
| cal_advised | output | 1 | Gain changed since the last completed run |

## Verification
Results are due at fixed cycle offsets from each stimulus:
- `cal_busy` rises one cycle after the select edge or `manual_go` pulse is sampled.
- `short_inputs` first appears in busy cycle SETTLE_CYC+1.
- The final code, `code_valid` and the `cal_advised` clear land in the cycle that `cal_busy` falls, SETTLE_CYC + CODE_W*SLOT_CYC cycles after the start.
- A standby request shows in the first cycle after `chip_on` is sampled low.

The driver queues the expected code for each run when it issues the trigger. A monitor samples on the falling clock edge and counts busy and shorted cycles. When `cal_busy` falls it pops the queue and compares against that exact cycle. A start seen with an empty queue is flagged as an unwanted run. Point checks of the ignore and standby rules are sampled one or a few falling edges after their stimulus.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SEARCH = 2'd2
    } ocal_state_e;

    function automatic int ns_to_cycles(input int clk_mhz, input int dur_ns);
        return (clk_mhz * dur_ns) / 1000;
    endfunction

endpackage

// File: rtl/ocal_trigger.sv
module ocal_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_on,
    input  logic gain_hi,
    input  logic link_sel_n,
    input  logic word_written,
    input  logic manual_go,
    input  logic busy,
    input  logic clear_advice,
    output logic start_req,
    output logic advised
);

    logic sel_q;
    logic gain_q;
    logic write_pending;
    logic sel_rise;
    logic gain_flip;
    logic frame_start;

    assign sel_rise    = link_sel_n & ~sel_q;
    assign gain_flip   = gain_hi ^ gain_q;
    assign frame_start = sel_rise & (write_pending | word_written);
    assign start_req   = chip_on & ~busy & (frame_start | manual_go);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            gain_q <= 1'b0;
        end else begin
            sel_q  <= link_sel_n;
            gain_q <= gain_hi;
        end
    end

    // every select rising edge consumes the pending write, accepted or not
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_pending <= 1'b0;
        end else if (sel_rise) begin
            write_pending <= 1'b0;
        end else if (word_written) begin
            write_pending <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            advised <= 1'b0;
        end else if (gain_flip) begin
            advised <= 1'b1;
        end else if (clear_advice) begin
            advised <= 1'b0;
        end
    end

endmodule

// File: rtl/ocal_timer.sv
module ocal_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/ocal_sar.sv
module ocal_sar #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              init,
    input  logic              step,
    input  logic              cmp_high,
    output logic [CODE_W-1:0] code,
    output logic              last
);

    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

    logic [IDX_W-1:0] bit_idx;

    always_ff @(posedge clk) begin
        if (!rst_n || wipe || init) begin
            bit_idx <= TOP_IDX;
        end else if (step && (bit_idx != '0)) begin
            bit_idx <= bit_idx - 1'b1;
        end
    end

    assign last = (bit_idx == '0);

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        localparam logic START_VAL = (i == CODE_W - 1);
        logic judge_here;
        logic trial_next;

        assign judge_here = step && (bit_idx == IDX_W'(i));
        if (i < CODE_W - 1) begin : g_trial
            assign trial_next = step && (bit_idx == IDX_W'(i + 1));
        end else begin : g_top
            assign trial_next = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n || wipe || init) begin
                code[i] <= START_VAL;
            end else if (judge_here && cmp_high) begin
                code[i] <= 1'b0;
            end else if (trial_next) begin
                code[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
    import ocal_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_NS = 500,
    parameter int SEARCH_NS = 2500,
    parameter int CODE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_on,
    input  logic              gain_hi,
    input  logic              link_sel_n,
    input  logic              word_written,
    input  logic              manual_go,
    input  logic              cmp_high,
    output logic              cal_busy,
    output logic              short_inputs,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid,
    output logic              cal_advised
);

    localparam int SETTLE_CYC = ns_to_cycles(CLK_MHZ, SETTLE_NS);
    localparam int SEARCH_CYC = ns_to_cycles(CLK_MHZ, SEARCH_NS);
    localparam int SLOT_CYC   = SEARCH_CYC / CODE_W;
    localparam int MAX_CYC    = (SETTLE_CYC > SLOT_CYC) ? SETTLE_CYC : SLOT_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SLOT_LOAD   = CNT_W'(SLOT_CYC - 1);

    ocal_state_e state;
    ocal_state_e state_nxt;

    logic             start_req;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sar_init;
    logic             sar_step;
    logic             sar_last;
    logic             run_done;

    ocal_trigger u_trigger (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_on      (chip_on),
        .gain_hi      (gain_hi),
        .link_sel_n   (link_sel_n),
        .word_written (word_written),
        .manual_go    (manual_go),
        .busy         (cal_busy),
        .clear_advice (run_done),
        .start_req    (start_req),
        .advised      (cal_advised)
    );

    ocal_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ocal_sar #(.CODE_W(CODE_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (~chip_on),
        .init     (sar_init),
        .step     (sar_step),
        .cmp_high (cmp_high),
        .code     (dac_code),
        .last     (sar_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and sequencing strobes
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sar_init  = 1'b0;
        sar_step  = 1'b0;
        run_done  = 1'b0;
        if (!chip_on) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state_nxt = ST_SETTLE;
                        tmr_load  = 1'b1;
                        tmr_val   = SETTLE_LOAD;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expired) begin
                        state_nxt = ST_SEARCH;
                        tmr_load  = 1'b1;
                        tmr_val   = SLOT_LOAD;
                        sar_init  = 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (tmr_expired) begin
                        sar_step = 1'b1;
                        if (sar_last) begin
                            state_nxt = ST_IDLE;
                            run_done  = 1'b1;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = SLOT_LOAD;
                        end
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        cal_busy     = (state != ST_IDLE);
        short_inputs = (state == ST_SEARCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !chip_on || sar_init) begin
            code_valid <= 1'b0;
        end else if (run_done) begin
            code_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/ocal_checker.sv
module ocal_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_on,
    input logic              cal_busy,
    input logic              short_inputs,
    input logic [CODE_W-1:0] dac_code,
    input logic              code_valid
);

    p_short_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        short_inputs |-> cal_busy)
        else $error("short_inputs without a run");

    p_standby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_on |=> (!cal_busy && !code_valid))
        else $error("standby left a run or valid code");

    p_valid_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> ($past(cal_busy) && !cal_busy))
        else $error("code_valid rose without a finished run");

    p_start_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> $past(chip_on))
        else $error("run started in standby");

    p_code_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && chip_on) |=> $stable(dac_code))
        else $error("dac_code moved while idle");

endmodule

bind offset_cal_seq ocal_checker #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_on      (chip_on),
    .cal_busy     (cal_busy),
    .short_inputs (short_inputs),
    .dac_code     (dac_code),
    .code_valid   (code_valid)
);

// File: tb/offset_cal_seq_bench.sv
`timescale 1ns/1ps
module offset_cal_seq_bench;

    localparam int CODE_W     = 6;
    localparam int SETTLE_CYC = 100 * 500 / 1000;
    localparam int SLOT_CYC   = (100 * 2500 / 1000) / CODE_W;
    localparam int SEARCH_CYC = CODE_W * SLOT_CYC;
    localparam int BUSY_CYC   = SETTLE_CYC + SEARCH_CYC;
    localparam int MID        = 1 << (CODE_W - 1);

    typedef struct {
        int    code;
        bit    abort;
        string req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_on = 1'b1;
    logic              gain_hi = 1'b0;
    logic              link_sel_n = 1'b1;
    logic              word_written = 1'b0;
    logic              manual_go = 1'b0;
    logic              cmp_high;
    logic              cal_busy;
    logic              short_inputs;
    logic [CODE_W-1:0] dac_code;
    logic              code_valid;
    logic              cal_advised;
    logic [CODE_W-1:0] target = '0;

    int   checks = 0;
    int   errors = 0;
    bit   summary_done = 1'b0;
    exp_t sb_q[$];

    // comparator model: offset is above zero when the code exceeds the target
    assign cmp_high = (dac_code > target);

    always #5 clk = ~clk;

    offset_cal_seq u_offset_cal_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_on      (chip_on),
        .gain_hi      (gain_hi),
        .link_sel_n   (link_sel_n),
        .word_written (word_written),
        .manual_go    (manual_go),
        .cmp_high     (cmp_high),
        .cal_busy     (cal_busy),
        .short_inputs (short_inputs),
        .dac_code     (dac_code),
        .code_valid   (code_valid),
        .cal_advised  (cal_advised)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // monitor: counts each run and compares it against the scoreboard
    int  busy_n = 0;
    int  short_n = 0;
    int  first_short = 0;
    bit  prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cal_busy && !prev_busy && sb_q.size() == 0) begin
                check(1'b0, "unexpected run start (R3 R7 R8 R9)", 1, 0);
            end
            if (cal_busy) begin
                busy_n++;
                if (short_inputs) begin
                    short_n++;
                    if (first_short == 0) first_short = busy_n;
                end
            end
            if (!cal_busy && prev_busy && sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.abort) begin
                    check(dac_code == CODE_W'(MID), "R8 abort code", int'(dac_code), MID);
                    check(!code_valid, "R8 abort valid", int'(code_valid), 0);
                end else begin
                    check(dac_code == CODE_W'(e.code), {e.req, " R6 code"}, int'(dac_code), e.code);
                    check(code_valid, "R6 valid at end", int'(code_valid), 1);
                    check(busy_n == BUSY_CYC, "R5 busy length", busy_n, BUSY_CYC);
                    check(short_n == SEARCH_CYC, "R5 short length", short_n, SEARCH_CYC);
                    check(first_short == SETTLE_CYC + 1, "R5 settle before short",
                          first_short, SETTLE_CYC + 1);
                end
            end
            if (!cal_busy) begin
                busy_n = 0;
                short_n = 0;
                first_short = 0;
            end
            prev_busy = cal_busy;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input bit with_write);
        link_sel_n = 1'b0;
        tick(1);
        if (with_write) begin
            word_written = 1'b1;
            tick(1);
            word_written = 1'b0;
        end
        tick(1);
        link_sel_n = 1'b1;
        tick(1);
    endtask

    task automatic go_pulse();
        manual_go = 1'b1;
        tick(1);
        manual_go = 1'b0;
    endtask

    task automatic push(input int code, input bit abort, input string req);
        exp_t e;
        e.code = code;
        e.abort = abort;
        e.req = req;
        sb_q.push_back(e);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(!cal_busy, "R1 busy", int'(cal_busy), 0);
        check(!short_inputs, "R1 short", int'(short_inputs), 0);
        check(dac_code == CODE_W'(MID), "R1 code", int'(dac_code), MID);
        check(!code_valid, "R1 valid", int'(code_valid), 0);
        check(!cal_advised, "R1 advised", int'(cal_advised), 0);

        // R2: write then select release
        target = 6'd45;
        push(45, 1'b0, "R2");
        frame(1'b1);
        check(cal_busy, "R2 busy after select edge", int'(cal_busy), 1);
        check(!short_inputs, "R5 no short while settling", int'(short_inputs), 0);
        tick(BUSY_CYC + 4);

        // R3: select edge without a write
        frame(1'b0);
        tick(5);
        check(!cal_busy, "R3 no run without write", int'(cal_busy), 0);

        // R4: manual trigger
        target = 6'd0;
        push(0, 1'b0, "R4");
        go_pulse();
        check(cal_busy, "R4 busy after manual", int'(cal_busy), 1);
        tick(BUSY_CYC + 4);

        // R7: triggers during a run are dropped
        target = 6'd63;
        push(63, 1'b0, "R7");
        go_pulse();
        tick(60);
        go_pulse();
        frame(1'b1);
        tick(BUSY_CYC + 20);
        check(!cal_busy, "R7 no second run", int'(cal_busy), 0);

        // R9: gain change advises, does not start
        gain_hi = 1'b1;
        tick(3);
        check(cal_advised, "R9 advised set", int'(cal_advised), 1);
        check(!cal_busy, "R9 no run from gain", int'(cal_busy), 0);
        target = 6'd1;
        push(1, 1'b0, "R9");
        go_pulse();
        tick(BUSY_CYC + 4);
        check(!cal_advised, "R9 advised cleared", int'(cal_advised), 0);

        // R8: standby aborts and invalidates
        target = 6'd10;
        push(0, 1'b1, "R8");
        go_pulse();
        tick(100);
        chip_on = 1'b0;
        tick(1);
        check(!cal_busy, "R8 busy in standby", int'(cal_busy), 0);
        check(!short_inputs, "R8 short in standby", int'(short_inputs), 0);
        check(!code_valid, "R8 valid in standby", int'(code_valid), 0);
        check(dac_code == CODE_W'(MID), "R8 code midscale", int'(dac_code), MID);
        frame(1'b1);
        go_pulse();
        tick(5);
        check(!cal_busy, "R8 triggers ignored in standby", int'(cal_busy), 0);
        chip_on = 1'b1;
        tick(3);
        check(!code_valid, "R8 valid after wake", int'(code_valid), 0);
        check(dac_code == CODE_W'(MID), "R8 code after wake", int'(dac_code), MID);
        target = 6'd20;
        push(20, 1'b0, "R8");
        frame(1'b1);
        tick(BUSY_CYC + 4);

        // R10: idle code holds while the comparator moves
        target = 6'd0;
        tick(50);
        target = 6'd63;
        tick(50);
        check(dac_code == 6'd20, "R10 code held idle", int'(dac_code), 20);
        check(code_valid, "R10 valid held", int'(code_valid), 1);
        check(sb_q.size() == 0, "R6 all runs seen", sb_q.size(), 0);

        summary();
        $finish;
    end

endmodule